// File: doc/BRIEF.md
# Masked Vector Execution Unit

This block performs one element-wise integer operation across two vector operands, element by element, under the control of a per-element predicate register (the mask). Each arithmetic result leaves through a register-file write port as an element index, a data word and a write strobe. An element whose mask bit is clear gets no strobe, so the destination register keeps the value it already had.

Two execution modes are available. In the plain mode the unit spends one cycle on every element up to the vector length and uses the mask only to gate the write strobe. In the skipping mode it jumps from one set mask bit to the next, so a run takes as many cycles as there are enabled elements. Two further opcodes write the mask itself. One enables every element, and the other sets each bit from an unsigned greater-than test of the element against a scalar. A one-cycle completion pulse carries the number of busy cycles the operation used. The caller must hold the operand vectors and the scalar stable while the unit is busy.

Top module: `masked_vec_unit`

## Requirements
- R1: After reset the unit is idle (busy low, done low, no write strobe) and every mask bit is 1.
- R2: Opcode encodings: 0 gives a+b, 1 gives a-b, 2 gives a AND b, 3 gives a OR b, 4 gives a XOR b, 5 gives the unsigned maximum of a and b. All results are taken modulo 2^DATA_W, where a and b are element i of vec_a_i and vec_b_i (element i sits at bits [i*DATA_W +: DATA_W]).
- R3: Plain mode (dense_i=0): element i is presented on the write port in busy cycle i, for i from 0 to L-1. L is the vector length, and a value above NUM_ELEM is treated as NUM_ELEM. The run takes max(L,1) busy cycles.
- R4: An element whose mask bit is 0 gets no write strobe, so its destination keeps its old value.
- R5: Skipping mode (dense_i=1): only elements below L with a set mask bit are written, one per busy cycle, in ascending index order. The run takes max(count of such elements, 1) busy cycles.
- R6: In skipping mode, if no mask bit is set below L, the run takes exactly one busy cycle and makes no write.
- R7: Opcode 6 sets mask bits 0 to L-1 to 1, leaves the other bits unchanged, takes one busy cycle and makes no write.
- R8: Opcode 7 sets mask bit i (for i below L) to 1 when element i of vec_a_i is greater than scalar_i as an unsigned number, and to 0 otherwise. It leaves bits at L and above unchanged, takes one busy cycle and makes no write. Arithmetic opcodes never change the mask.
- R9: done_o is high for exactly one cycle, the cycle right after the last busy cycle, with busy_o low. In that cycle cycles_o equals the number of busy cycles of the run.
- R10: A start pulse while busy_o is high is ignored, and the run in progress finishes unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start_i | input | 1 | Starts an operation when the unit is idle |
| op_i | input | 3 | Opcode (see R2, R7, R8) |
| dense_i | input | 1 | 1 selects skipping mode, 0 selects plain mode |
| vlen_i | input | LEN_W (4) | Vector length, clamped to NUM_ELEM |
| vec_a_i | input | NUM_ELEM*DATA_W (128) | First operand vector, held while busy |
| vec_b_i | input | NUM_ELEM*DATA_W (128) | Second operand vector, held while busy |
| scalar_i | input | DATA_W (16) | Scalar for the compare opcode, held while busy |
| busy_o | output | 1 | Operation in progress |
| wr_en_o | output | 1 | Register-file write strobe |
| wr_idx_o | output | IDX_W (3) | Element index being written |
| wr_data_o | output | DATA_W (16) | Element result |
| mask_o | output | NUM_ELEM (8) | Current mask register |
| done_o | output | 1 | One-cycle completion pulse |
| cycles_o | output | LEN_W (4) | Busy-cycle count of the finished run |

## Verification
The unit accepts start at a rising edge, and element k of a plain run appears on the write port during the k-th cycle after that edge. In a skipping run the k-th enabled element appears in that cycle instead. A mask opcode changes mask_o at the edge that ends its single busy cycle, and done_o with cycles_o follows in the cycle after the last busy one. The bench samples at the falling edge and pops one expected write from its queue each time the strobe is high, so every result is compared in the cycle it is due. Busy cycles counted at the falling edge are compared with cycles_o and with the count the bench expects. The mask is compared with the bench's model after every run, and done_o is checked to be low one cycle after the pulse.

// File: rtl/mvu_pkg.sv
package mvu_pkg;
    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_SUB  = 3'd1,
        OP_AND  = 3'd2,
        OP_OR   = 3'd3,
        OP_XOR  = 3'd4,
        OP_MAX  = 3'd5,
        OP_MSET = 3'd6,
        OP_MCMP = 3'd7
    } vop_e;

    function automatic logic is_mask_op(vop_e o);
        return (o == OP_MSET) || (o == OP_MCMP);
    endfunction
endpackage

// File: rtl/mvu_elem_alu.sv
module mvu_elem_alu
    import mvu_pkg::*;
#(
    parameter int DATA_W = 16
) (
    input  vop_e              op,
    input  logic [DATA_W-1:0] a,
    input  logic [DATA_W-1:0] b,
    output logic [DATA_W-1:0] y
);
    always_comb begin
        case (op)
            OP_ADD:  y = a + b;
            OP_SUB:  y = a - b;
            OP_AND:  y = a & b;
            OP_OR:   y = a | b;
            OP_XOR:  y = a ^ b;
            OP_MAX:  y = (a > b) ? a : b;
            default: y = '0;
        endcase
    end
endmodule

// File: rtl/mvu_mask_gen.sv
module mvu_mask_gen
    import mvu_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int DATA_W   = 16,
    parameter int LEN_W    = 4
) (
    input  vop_e                       op,
    input  logic [LEN_W-1:0]           len,
    input  logic [NUM_ELEM-1:0]        mask_cur,
    input  logic [NUM_ELEM*DATA_W-1:0] vec_a,
    input  logic [DATA_W-1:0]          scalar,
    output logic [NUM_ELEM-1:0]        mask_new
);
    for (genvar i = 0; i < NUM_ELEM; i++) begin : g_lane
        logic in_len;
        logic gt;
        assign in_len = LEN_W'(i) < len;
        assign gt     = vec_a[i*DATA_W +: DATA_W] > scalar;
        assign mask_new[i] = !in_len ? mask_cur[i] :
                             (op == OP_MSET) ? 1'b1 : gt;
    end
endmodule

// File: rtl/mvu_next_set.sv
module mvu_next_set #(
    parameter int NUM_ELEM = 8,
    parameter int IDX_W    = 3,
    parameter int FROM_W   = 4
) (
    input  logic [NUM_ELEM-1:0] elig,
    input  logic [FROM_W-1:0]   from,
    output logic                found,
    output logic [IDX_W-1:0]    idx
);
    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = NUM_ELEM - 1; i >= 0; i--) begin
            if (elig[i] && (FROM_W'(i) >= from)) begin
                found = 1'b1;
                idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/masked_vec_unit.sv
module masked_vec_unit
    import mvu_pkg::*;
#(
    parameter int NUM_ELEM = 8,
    parameter int DATA_W   = 16,
    localparam int IDX_W   = $clog2(NUM_ELEM),
    localparam int LEN_W   = IDX_W + 1
) (
    input  logic                       clk,
    input  logic                       rst_n,
    input  logic                       start_i,
    input  logic [2:0]                 op_i,
    input  logic                       dense_i,
    input  logic [LEN_W-1:0]           vlen_i,
    input  logic [NUM_ELEM*DATA_W-1:0] vec_a_i,
    input  logic [NUM_ELEM*DATA_W-1:0] vec_b_i,
    input  logic [DATA_W-1:0]          scalar_i,
    output logic                       busy_o,
    output logic                       wr_en_o,
    output logic [IDX_W-1:0]           wr_idx_o,
    output logic [DATA_W-1:0]          wr_data_o,
    output logic [NUM_ELEM-1:0]        mask_o,
    output logic                       done_o,
    output logic [LEN_W-1:0]           cycles_o
);
    typedef struct packed {
        logic                busy;
        logic                dense;
        vop_e                op;
        logic [LEN_W-1:0]    len;
        logic [IDX_W-1:0]    idx;
        logic [LEN_W-1:0]    cnt;
        logic [NUM_ELEM-1:0] mask;
        logic                done;
        logic [LEN_W-1:0]    cyc;
    } st_t;

    st_t q, d;

    function automatic logic [NUM_ELEM-1:0] len_mask(input logic [LEN_W-1:0] l);
        logic [NUM_ELEM-1:0] m;
        for (int i = 0; i < NUM_ELEM; i++) m[i] = LEN_W'(i) < l;
        return m;
    endfunction

    logic [LEN_W-1:0]    len_in;
    logic [NUM_ELEM-1:0] elig_in, elig_q, mask_new;
    logic                first_found, next_found;
    logic [IDX_W-1:0]    first_idx, next_idx;
    logic [LEN_W-1:0]    idx_plus1;
    logic [DATA_W-1:0]   a_el, b_el;

    assign len_in    = (vlen_i > LEN_W'(NUM_ELEM)) ? LEN_W'(NUM_ELEM) : vlen_i;
    assign elig_in   = q.mask & len_mask(len_in);
    assign elig_q    = q.mask & len_mask(q.len);
    assign idx_plus1 = LEN_W'(q.idx) + LEN_W'(1);
    assign a_el      = vec_a_i[int'(q.idx)*DATA_W +: DATA_W];
    assign b_el      = vec_b_i[int'(q.idx)*DATA_W +: DATA_W];

    mvu_next_set #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W), .FROM_W(LEN_W)) u_first (
        .elig(elig_in), .from(LEN_W'(0)), .found(first_found), .idx(first_idx)
    );

    mvu_next_set #(.NUM_ELEM(NUM_ELEM), .IDX_W(IDX_W), .FROM_W(LEN_W)) u_next (
        .elig(elig_q), .from(idx_plus1), .found(next_found), .idx(next_idx)
    );

    mvu_mask_gen #(.NUM_ELEM(NUM_ELEM), .DATA_W(DATA_W), .LEN_W(LEN_W)) u_mask (
        .op(q.op), .len(q.len), .mask_cur(q.mask), .vec_a(vec_a_i),
        .scalar(scalar_i), .mask_new(mask_new)
    );

    mvu_elem_alu #(.DATA_W(DATA_W)) u_alu (
        .op(q.op), .a(a_el), .b(b_el), .y(wr_data_o)
    );

    always_comb begin
        logic last;
        d      = q;
        d.done = 1'b0;
        last   = 1'b0;
        if (!q.busy) begin
            if (start_i) begin
                d.busy  = 1'b1;
                d.op    = vop_e'(op_i);
                d.dense = dense_i;
                d.len   = len_in;
                d.cnt   = '0;
                d.idx   = (dense_i && first_found) ? first_idx : '0;
            end
        end else begin
            d.cnt = q.cnt + LEN_W'(1);
            if (is_mask_op(q.op)) begin
                last   = 1'b1;
                d.mask = mask_new;
            end else if (q.dense) begin
                last  = !next_found;
                d.idx = next_idx;
            end else begin
                last  = idx_plus1 >= q.len;
                d.idx = q.idx + 1'b1;
            end
            if (last) begin
                d.busy = 1'b0;
                d.done = 1'b1;
                d.cyc  = q.cnt + LEN_W'(1);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q      <= '0;
            q.mask <= '1;
        end else begin
            q <= d;
        end
    end

    assign busy_o   = q.busy;
    assign wr_en_o  = q.busy && !is_mask_op(q.op) && q.mask[q.idx] &&
                      (LEN_W'(q.idx) < q.len);
    assign wr_idx_o = q.idx;
    assign mask_o   = q.mask;
    assign done_o   = q.done;
    assign cycles_o = q.cyc;

    assert_done_after_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> ($past(busy_o) && !busy_o));

    assert_plain_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && $past(busy_o) && !q.dense) |-> (wr_idx_o == IDX_W'($past(wr_idx_o) + 1'b1)));

    assert_dense_ascending_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en_o && q.dense && $past(wr_en_o)) |-> (wr_idx_o > $past(wr_idx_o)));

    assert_start_ignored_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && start_i) |=> (q.op == $past(q.op) && q.len == $past(q.len)));

    assert_arith_keeps_mask_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !is_mask_op(q.op)) |=> $stable(mask_o));
endmodule

// File: tb/masked_vec_unit_bench.sv
`timescale 1ns/1ps
module masked_vec_unit_bench;
    import mvu_pkg::*;
    localparam int N = 8;
    localparam int W = 16;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0;
    logic [2:0] op_i = '0;
    logic dense_i = 1'b0;
    logic [3:0] vlen_i = '0;
    logic [N*W-1:0] vec_a_i = '0, vec_b_i = '0;
    logic [W-1:0] scalar_i = '0;
    logic busy_o, wr_en_o, done_o;
    logic [2:0] wr_idx_o;
    logic [W-1:0] wr_data_o;
    logic [N-1:0] mask_o;
    logic [3:0] cycles_o;

    always #10 clk = ~clk;

    masked_vec_unit u_masked_vec_unit (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i), .dense_i(dense_i),
        .vlen_i(vlen_i), .vec_a_i(vec_a_i), .vec_b_i(vec_b_i), .scalar_i(scalar_i),
        .busy_o(busy_o), .wr_en_o(wr_en_o), .wr_idx_o(wr_idx_o), .wr_data_o(wr_data_o),
        .mask_o(mask_o), .done_o(done_o), .cycles_o(cycles_o)
    );

    typedef struct { int idx; logic [W-1:0] data; } exp_t;
    exp_t sb[$];
    int n_cmp = 0, n_bad = 0, busy_seen = 0;
    logic [N-1:0] mask_m = '1;
    bit finished = 0;

    task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [W-1:0] ref_op(input int op, input logic [W-1:0] a, input logic [W-1:0] b);
        case (op)
            0: return a + b;
            1: return a - b;
            2: return a & b;
            3: return a | b;
            4: return a ^ b;
            default: return (a > b) ? a : b;
        endcase
    endfunction

    function automatic logic [N*W-1:0] mk_vec(input int seed);
        logic [N*W-1:0] v;
        for (int i = 0; i < N; i++) v[i*W +: W] = W'(seed * (i + 3) * 977 + i * 131);
        return v;
    endfunction

    // monitor: compares each write as it appears
    always @(negedge clk) begin
        if (rst_n && busy_o) busy_seen++;
        if (rst_n && wr_en_o) begin
            if (sb.size() == 0) begin
                chk(0, "R4 unexpected write idx", wr_idx_o, -1);
            end else begin
                exp_t e;
                e = sb.pop_front();
                chk(int'(wr_idx_o) == e.idx, "R3/R5 write index", wr_idx_o, e.idx);
                chk(wr_data_o == e.data, "R2 write data", wr_data_o, e.data);
            end
        end
    end

    task automatic run(input int op, input bit dense, input int vlen,
                       input logic [N*W-1:0] a, input logic [N*W-1:0] b,
                       input logic [W-1:0] s, input bit poke, input string tag);
        int L, pop, exp_cyc;
        L = (vlen > N) ? N : vlen;
        pop = 0;
        if (op >= 6) begin
            for (int i = 0; i < L; i++)
                mask_m[i] = (op == 6) ? 1'b1 : (a[i*W +: W] > s);
            exp_cyc = 1;
        end else begin
            for (int i = 0; i < L; i++) if (mask_m[i]) begin
                exp_t e;
                e.idx = i;
                e.data = ref_op(op, a[i*W +: W], b[i*W +: W]);
                sb.push_back(e);
                pop++;
            end
            exp_cyc = dense ? ((pop > 0) ? pop : 1) : ((L > 0) ? L : 1);
        end
        @(negedge clk);
        op_i = op[2:0]; dense_i = dense; vlen_i = vlen[3:0];
        vec_a_i = a; vec_b_i = b; scalar_i = s; start_i = 1'b1;
        busy_seen = 0;
        @(negedge clk);
        start_i = 1'b0;
        if (poke) begin
            @(negedge clk);
            start_i = 1'b1; op_i = 3'd6; vlen_i = 4'd8; dense_i = 1'b1;
            @(negedge clk);
            start_i = 1'b0; op_i = op[2:0];
        end
        while (!done_o) @(negedge clk);
        chk(cycles_o == 4'(exp_cyc), {tag, " R9 cycles_o"}, cycles_o, exp_cyc);
        chk(busy_seen == exp_cyc, {tag, " R9 busy cycles"}, busy_seen, exp_cyc);
        chk(busy_o == 1'b0, {tag, " R9 idle at done"}, busy_o, 0);
        chk(sb.size() == 0, {tag, " R4 missing writes"}, sb.size(), 0);
        sb.delete();
        chk(mask_o == mask_m, {tag, " R7/R8 mask"}, mask_o, mask_m);
        @(negedge clk);
        chk(done_o == 1'b0, {tag, " R9 single pulse"}, done_o, 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!finished) begin
            n_bad++; n_cmp++;
            $display("FAIL watchdog actual=hung expected=finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(busy_o == 0, "R1 busy", busy_o, 0);
        chk(done_o == 0, "R1 done", done_o, 0);
        chk(wr_en_o == 0, "R1 wr_en", wr_en_o, 0);
        chk(mask_o == '1, "R1 mask", mask_o, 8'hff);
        rst_n = 1'b1;
        @(negedge clk);
        // R2/R3 full-mask plain add
        run(0, 0, 8, mk_vec(1), mk_vec(2), '0, 0, "R2 add");
        // R8 compare sets mask pattern
        run(7, 0, 8, mk_vec(3), mk_vec(0), 16'h8000, 0, "R8 cmp");
        // R4 plain subtract under mask
        run(1, 0, 8, mk_vec(5), mk_vec(4), '0, 0, "R4 sub");
        // R5 skipping xor
        run(4, 1, 8, mk_vec(6), mk_vec(7), '0, 0, "R5 xor");
        // R8 compare limited to vlen 5
        run(7, 0, 5, mk_vec(9), mk_vec(0), 16'h4000, 0, "R8 cmp len5");
        run(2, 1, 8, mk_vec(10), mk_vec(11), '0, 0, "R5 and");
        // R7 set-all over 3 elements
        run(7, 0, 8, mk_vec(1), mk_vec(0), 16'hffff, 0, "R8 cmp zero");
        run(6, 0, 3, mk_vec(0), mk_vec(0), '0, 0, "R7 set3");
        run(3, 1, 8, mk_vec(12), mk_vec(13), '0, 0, "R5 or");
        // R6 empty mask in skipping mode
        run(7, 0, 8, mk_vec(1), mk_vec(0), 16'hffff, 0, "R8 cmp clear");
        run(5, 1, 8, mk_vec(14), mk_vec(15), '0, 0, "R6 empty");
        run(5, 0, 8, mk_vec(14), mk_vec(15), '0, 0, "R4 plain empty");
        // R3 zero length and clamp
        run(6, 0, 12, mk_vec(0), mk_vec(0), '0, 0, "R7 clamp");
        run(0, 0, 0, mk_vec(2), mk_vec(3), '0, 0, "R3 len0");
        run(5, 0, 12, mk_vec(16), mk_vec(17), '0, 0, "R3 clamp max");
        // R10 start pulse while busy
        run(7, 0, 8, mk_vec(18), mk_vec(0), 16'h9000, 0, "R8 cmp2");
        run(0, 0, 8, mk_vec(19), mk_vec(20), '0, 1, "R10 poke plain");
        run(1, 1, 8, mk_vec(21), mk_vec(22), '0, 0, "R5 sub");
        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule